// File: doc/BRIEF.md
# Receive Descriptor Ring Engine

This block stores incoming frames into memory under the control of a small ring of receive descriptors kept in local storage. Each descriptor holds a 16-bit status word, a 16-bit length and a 32-bit buffer address. Software arms a descriptor by setting its empty bit. The engine takes the descriptor at its current index when a frame starts and streams the frame bytes out of a byte-wide write port, starting at that descriptor's buffer address. It then writes back the length and the final status and moves to the next descriptor. The descriptor that carries the wrap bit, or the last one in storage, sends the index back to 0.

If a frame begins while the current descriptor is still owned by software, the engine raises a busy event and halts. It drops every frame until software issues clear-halt. Software can also ask for a graceful stop. The frame in progress completes, the engine then reports a stop-complete event, and it drops frames until the request is withdrawn. Both events are sticky and are cleared by writing one. Frames are byte-wide, with valid, last and error strobes. The source leaves at least two idle cycles between the last byte of one frame and the first byte of the next.

Top module: `rxr_ring_engine`

## Requirements
- R1: After reset or an `init_i` pulse, every descriptor has status 0x8000 (bit 15 = empty) except the last, which has 0xA000 (bit 13 = wrap). All lengths are 0, the current index is 0, and the engine is neither halted nor busy. An `init_i` pulse leaves the buffer addresses unchanged.
- R2: When a frame starts on an empty descriptor, byte k of the frame is written to the descriptor's buffer address plus k, in arrival order.
- R3: After the last byte, the descriptor length equals the number of bytes stored, counting the trailing 4-byte check sequence. The status has the empty bit cleared and the wrap bit kept, and the index advances by one. A one-byte frame follows the same rule.
- R4: If `rx_err_i` is high on any byte of a frame, status bit 1 is set. A clean frame leaves status bits 2..0 at 0.
- R5: The length field of a descriptor is written in an earlier cycle than its status word, so the empty bit is the last thing cleared.
- R6: After the engine uses a descriptor whose wrap bit is set, or the descriptor at index NDESC-1, the index returns to 0.
- R7: If the current descriptor is not empty when a frame starts, the busy event is set and the engine halts. No buffer write is made and the descriptor is not changed.
- R8: While halted, the engine drops frames and leaves the index unchanged. A `clr_halt_i` pulse releases the halt, and the next frame is stored at the same index.
- R9: `evt_clr_i` bit 0 clears the busy event and bit 1 clears the stop-complete event. If an event is set in the same cycle it is cleared, the event stays set.
- R10: No more than `max_len_i` bytes of a frame are written. A longer frame is truncated, its length field holds `max_len_i`, and status bit 2 (overrun) is set.
- R11: A `stop_req_i` raised during a frame lets that frame complete. The engine then raises `stopped_o` and the stop-complete event. While stopped, frames are dropped without a busy event. Lowering `stop_req_i` resumes reception.
- R12: Software reads and writes descriptor fields through `sw_sel_i`: 0 selects status, 1 selects length, 2 selects buffer address. Status and length use data bits 15..0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| init_i | input | 1 | Start-up pulse: rearm the ring and reset the index |
| max_len_i | input | 16 | Largest number of bytes stored per frame |
| rx_valid_i | input | 1 | Frame byte valid |
| rx_data_i | input | 8 | Frame byte |
| rx_last_i | input | 1 | Last byte of the frame |
| rx_err_i | input | 1 | Error seen on this byte |
| stop_req_i | input | 1 | Graceful stop request (level) |
| clr_halt_i | input | 1 | Release the halt |
| evt_clr_i | input | 2 | Write-one-to-clear: bit 0 busy, bit 1 stop-complete |
| sw_we_i | input | 1 | Descriptor field write strobe |
| sw_idx_i | input | IDXW | Descriptor index for software access |
| sw_sel_i | input | 2 | Field select: 0 status, 1 length, 2 address |
| sw_wdata_i | input | 32 | Descriptor write data |
| sw_rdata_o | output | 32 | Selected descriptor field |
| buf_we_o | output | 1 | Buffer byte write strobe |
| buf_addr_o | output | 32 | Buffer byte address |
| buf_data_o | output | 8 | Buffer byte data |
| cur_idx_o | output | IDXW | Current descriptor index |
| halted_o | output | 1 | Engine halted after a busy event |
| stopped_o | output | 1 | Engine in graceful stop |
| busy_evt_o | output | 1 | Sticky busy event |
| stop_evt_o | output | 1 | Sticky stop-complete event |

## Verification
Two pairs of functions can fall in the same cycle. The first pair is the busy-event set and its write-one-to-clear. The bench provokes this by driving `evt_clr_i[0]` in the same cycle as the first byte of a frame aimed at a descriptor that software still owns, and it expects the busy flag to be set afterwards. The second pair is a stop request and an incoming frame. The bench raises `stop_req_i` in the middle of a frame and expects every byte plus a full write-back before `stopped_o` rises. It then sends a frame while stopped to a non-empty descriptor and expects neither buffer writes nor a busy event.

// File: rtl/rxr_pkg.sv
package rxr_pkg;

  // Status bit positions software decodes
  localparam int ST_EMPTY = 15;
  localparam int ST_WRAP  = 13;
  localparam int ST_OVR   = 2;
  localparam int ST_ERR   = 1;

  // Software field selects
  localparam logic [1:0] SEL_STAT = 2'd0;
  localparam logic [1:0] SEL_LEN  = 2'd1;
  localparam logic [1:0] SEL_PTR  = 2'd2;

  typedef enum logic [2:0] {
    S_IDLE   = 3'd0,
    S_RECV   = 3'd1,
    S_DROP   = 3'd2,
    S_WBLEN  = 3'd3,
    S_WBSTAT = 3'd4
  } rx_state_e;

  function automatic logic [15:0] fresh_status(input logic is_last);
    logic [15:0] s;
    s = '0;
    s[ST_EMPTY] = 1'b1;
    s[ST_WRAP]  = is_last;
    return s;
  endfunction

endpackage

// File: rtl/rxr_desc_mem.sv
module rxr_desc_mem
  import rxr_pkg::*;
#(
  parameter int NDESC = 8,
  parameter int IDXW  = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            init_i,
  input  logic [IDXW-1:0] eng_idx_i,
  input  logic            eng_len_we_i,
  input  logic [15:0]     eng_len_i,
  input  logic            eng_stat_we_i,
  input  logic [15:0]     eng_stat_i,
  output logic            eng_empty_o,
  output logic            eng_wrap_o,
  output logic [31:0]     eng_ptr_o,
  input  logic            sw_we_i,
  input  logic [IDXW-1:0] sw_idx_i,
  input  logic [1:0]      sw_sel_i,
  input  logic [31:0]     sw_wdata_i,
  output logic [31:0]     sw_rdata_o
);

  localparam int STW = NDESC * 16;
  localparam int PTW = NDESC * 32;

  logic [STW-1:0] stat_flat;
  logic [STW-1:0] len_flat;
  logic [PTW-1:0] ptr_flat;

  for (genvar g = 0; g < NDESC; g++) begin : g_ent
    logic [15:0] stat_r, stat_d;
    logic [15:0] len_r, len_d;
    logic [31:0] ptr_r, ptr_d;
    logic        sw_hit, eng_hit;

    assign sw_hit  = sw_we_i && (sw_idx_i == IDXW'(g));
    assign eng_hit = (eng_idx_i == IDXW'(g));

    // Priority: start-up, then engine write-back, then software
    always_comb begin
      stat_d = stat_r;
      len_d  = len_r;
      ptr_d  = ptr_r;
      if (sw_hit) begin
        case (sw_sel_i)
          SEL_STAT: stat_d = sw_wdata_i[15:0];
          SEL_LEN:  len_d  = sw_wdata_i[15:0];
          SEL_PTR:  ptr_d  = sw_wdata_i;
          default:  ;
        endcase
      end
      if (eng_len_we_i && eng_hit)  len_d  = eng_len_i;
      if (eng_stat_we_i && eng_hit) stat_d = eng_stat_i;
      if (init_i) begin
        stat_d = fresh_status(g == NDESC - 1);
        len_d  = '0;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        stat_r <= fresh_status(g == NDESC - 1);
        len_r  <= '0;
        ptr_r  <= '0;
      end else begin
        stat_r <= stat_d;
        len_r  <= len_d;
        ptr_r  <= ptr_d;
      end
    end

    assign stat_flat[g*16 +: 16] = stat_r;
    assign len_flat[g*16 +: 16]  = len_r;
    assign ptr_flat[g*32 +: 32]  = ptr_r;
  end

  logic [15:0] cur_stat;
  assign cur_stat    = stat_flat[{eng_idx_i, 4'b0} +: 16];
  assign eng_empty_o = cur_stat[ST_EMPTY];
  assign eng_wrap_o  = cur_stat[ST_WRAP];
  assign eng_ptr_o   = ptr_flat[{eng_idx_i, 5'b0} +: 32];

  always_comb begin
    case (sw_sel_i)
      SEL_STAT: sw_rdata_o = {16'b0, stat_flat[{sw_idx_i, 4'b0} +: 16]};
      SEL_LEN:  sw_rdata_o = {16'b0, len_flat[{sw_idx_i, 4'b0} +: 16]};
      SEL_PTR:  sw_rdata_o = ptr_flat[{sw_idx_i, 5'b0} +: 32];
      default:  sw_rdata_o = '0;
    endcase
  end

  // R5
  wb_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    eng_stat_we_i |-> ($past(eng_len_we_i) && ($past(eng_idx_i) == eng_idx_i)));

endmodule

// File: rtl/rxr_evt.sv
module rxr_evt #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         init_i,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] evt_o
);

  for (genvar g = 0; g < N; g++) begin : g_flag
    logic evt_q, evt_d;

    // A set in the same cycle as a clear keeps the flag
    always_comb begin
      evt_d = evt_q;
      if (clr_i[g]) evt_d = 1'b0;
      if (init_i)   evt_d = 1'b0;
      if (set_i[g]) evt_d = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) evt_q <= 1'b0;
      else        evt_q <= evt_d;
    end

    assign evt_o[g] = evt_q;

    // R9
    evt_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_i[g] && !set_i[g]) |=> !evt_q);

    // R9
    evt_set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      set_i[g] |=> evt_q);
  end

endmodule

// File: rtl/rxr_rx_ctrl.sv
module rxr_rx_ctrl
  import rxr_pkg::*;
#(
  parameter int NDESC = 8,
  parameter int IDXW  = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            init_i,
  input  logic [15:0]     max_len_i,
  input  logic            rx_valid_i,
  input  logic [7:0]      rx_data_i,
  input  logic            rx_last_i,
  input  logic            rx_err_i,
  input  logic            stop_req_i,
  input  logic            clr_halt_i,
  input  logic            desc_empty_i,
  input  logic            desc_wrap_i,
  input  logic [31:0]     desc_ptr_i,
  output logic [IDXW-1:0] idx_o,
  output logic            len_we_o,
  output logic [15:0]     len_o,
  output logic            stat_we_o,
  output logic [15:0]     stat_o,
  output logic            bwe_o,
  output logic [31:0]     baddr_o,
  output logic [7:0]      bdata_o,
  output logic            halted_o,
  output logic            stopped_o,
  output logic            busy_set_o,
  output logic            stop_done_o
);

  localparam logic [IDXW-1:0] LAST_IDX = IDXW'(NDESC - 1);

  rx_state_e       state_q, state_d;
  logic [IDXW-1:0] idx_q, idx_d;
  logic [15:0]     cnt_q, cnt_d;
  logic [31:0]     ptr_q, ptr_d;
  logic            err_q, err_d;
  logic            ovr_q, ovr_d;
  logic            wrap_q, wrap_d;
  logic            halted_q, halted_d;
  logic            stopped_q, stopped_d;
  logic            bwe_q, bwe_d;
  logic [31:0]     baddr_q, baddr_d;
  logic [7:0]      bdata_q, bdata_d;

  logic            acc;
  logic [31:0]     acc_base;
  logic [15:0]     acc_cnt;
  logic            busy_set, len_we, stat_we;

  // Next-state process
  always_comb begin
    state_d   = state_q;
    idx_d     = idx_q;
    cnt_d     = cnt_q;
    ptr_d     = ptr_q;
    err_d     = err_q;
    ovr_d     = ovr_q;
    wrap_d    = wrap_q;
    halted_d  = halted_q;
    stopped_d = stopped_q;
    bwe_d     = 1'b0;
    baddr_d   = baddr_q;
    bdata_d   = bdata_q;
    busy_set  = 1'b0;
    len_we    = 1'b0;
    stat_we   = 1'b0;
    acc       = 1'b0;
    acc_base  = ptr_q;
    acc_cnt   = cnt_q;

    case (state_q)
      S_IDLE: begin
        stopped_d = stop_req_i;
        if (rx_valid_i) begin
          if (stop_req_i || stopped_q || halted_q) begin
            if (!rx_last_i) state_d = S_DROP;
          end else if (!desc_empty_i) begin
            busy_set = 1'b1;
            halted_d = 1'b1;
            if (!rx_last_i) state_d = S_DROP;
          end else begin
            acc      = 1'b1;
            acc_base = desc_ptr_i;
            acc_cnt  = '0;
            ptr_d    = desc_ptr_i;
            wrap_d   = desc_wrap_i;
            err_d    = 1'b0;
            ovr_d    = 1'b0;
            cnt_d    = '0;
            state_d  = rx_last_i ? S_WBLEN : S_RECV;
          end
        end
      end
      S_RECV: begin
        if (rx_valid_i) begin
          acc = 1'b1;
          if (rx_last_i) state_d = S_WBLEN;
        end
      end
      S_DROP: begin
        if (rx_valid_i && rx_last_i) state_d = S_IDLE;
      end
      S_WBLEN: begin
        len_we  = 1'b1;
        state_d = S_WBSTAT;
      end
      S_WBSTAT: begin
        stat_we = 1'b1;
        idx_d   = (wrap_q || (idx_q == LAST_IDX)) ? '0 : idx_q + IDXW'(1);
        state_d = S_IDLE;
      end
      default: state_d = S_IDLE;
    endcase

    if (acc) begin
      err_d = err_d | rx_err_i;
      if (acc_cnt < max_len_i) begin
        bwe_d   = 1'b1;
        baddr_d = acc_base + {16'b0, acc_cnt};
        bdata_d = rx_data_i;
        cnt_d   = acc_cnt + 16'd1;
      end else begin
        ovr_d = 1'b1;
      end
    end

    if (clr_halt_i && !busy_set) halted_d = 1'b0;

    if (init_i) begin
      state_d  = S_IDLE;
      idx_d    = '0;
      halted_d = 1'b0;
      bwe_d    = 1'b0;
      busy_set = 1'b0;
      len_we   = 1'b0;
      stat_we  = 1'b0;
    end
  end

  // Register process
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= S_IDLE;
      idx_q     <= '0;
      cnt_q     <= '0;
      ptr_q     <= '0;
      err_q     <= 1'b0;
      ovr_q     <= 1'b0;
      wrap_q    <= 1'b0;
      halted_q  <= 1'b0;
      stopped_q <= 1'b0;
      bwe_q     <= 1'b0;
      baddr_q   <= '0;
      bdata_q   <= '0;
    end else begin
      state_q   <= state_d;
      idx_q     <= idx_d;
      cnt_q     <= cnt_d;
      ptr_q     <= ptr_d;
      err_q     <= err_d;
      ovr_q     <= ovr_d;
      wrap_q    <= wrap_d;
      halted_q  <= halted_d;
      stopped_q <= stopped_d;
      bwe_q     <= bwe_d;
      baddr_q   <= baddr_d;
      bdata_q   <= bdata_d;
    end
  end

  always_comb begin
    stat_o          = '0;
    stat_o[ST_WRAP] = wrap_q;
    stat_o[ST_OVR]  = ovr_q;
    stat_o[ST_ERR]  = err_q;
  end

  assign idx_o       = idx_q;
  assign len_we_o    = len_we;
  assign len_o       = cnt_q;
  assign stat_we_o   = stat_we;
  assign bwe_o       = bwe_q;
  assign baddr_o     = baddr_q;
  assign bdata_o     = bdata_q;
  assign halted_o    = halted_q;
  assign stopped_o   = stopped_q;
  assign busy_set_o  = busy_set;
  assign stop_done_o = stopped_d & ~stopped_q;

  // R6
  wrap_return_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_we && wrap_q) |=> (idx_q == '0));

  // R7
  busy_halts_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy_set |=> halted_q);

  // R8
  halt_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (halted_q && $past(halted_q)) |-> !bwe_q);

  // R10
  max_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_RECV) |-> (cnt_q <= max_len_i));

endmodule

// File: rtl/rxr_ring_engine.sv
module rxr_ring_engine #(
  parameter int NDESC = 8,
  localparam int IDXW = $clog2(NDESC)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            init_i,
  input  logic [15:0]     max_len_i,
  input  logic            rx_valid_i,
  input  logic [7:0]      rx_data_i,
  input  logic            rx_last_i,
  input  logic            rx_err_i,
  input  logic            stop_req_i,
  input  logic            clr_halt_i,
  input  logic [1:0]      evt_clr_i,
  input  logic            sw_we_i,
  input  logic [IDXW-1:0] sw_idx_i,
  input  logic [1:0]      sw_sel_i,
  input  logic [31:0]     sw_wdata_i,
  output logic [31:0]     sw_rdata_o,
  output logic            buf_we_o,
  output logic [31:0]     buf_addr_o,
  output logic [7:0]      buf_data_o,
  output logic [IDXW-1:0] cur_idx_o,
  output logic            halted_o,
  output logic            stopped_o,
  output logic            busy_evt_o,
  output logic            stop_evt_o
);

  logic [IDXW-1:0] idx;
  logic            len_we, stat_we;
  logic [15:0]     len_wb, stat_wb;
  logic            d_empty, d_wrap;
  logic [31:0]     d_ptr;
  logic            busy_set, stop_done;
  logic [1:0]      evts;

  rxr_desc_mem #(.NDESC(NDESC), .IDXW(IDXW)) mem_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .init_i        (init_i),
    .eng_idx_i     (idx),
    .eng_len_we_i  (len_we),
    .eng_len_i     (len_wb),
    .eng_stat_we_i (stat_we),
    .eng_stat_i    (stat_wb),
    .eng_empty_o   (d_empty),
    .eng_wrap_o    (d_wrap),
    .eng_ptr_o     (d_ptr),
    .sw_we_i       (sw_we_i),
    .sw_idx_i      (sw_idx_i),
    .sw_sel_i      (sw_sel_i),
    .sw_wdata_i    (sw_wdata_i),
    .sw_rdata_o    (sw_rdata_o)
  );

  rxr_rx_ctrl #(.NDESC(NDESC), .IDXW(IDXW)) ctrl_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .init_i       (init_i),
    .max_len_i    (max_len_i),
    .rx_valid_i   (rx_valid_i),
    .rx_data_i    (rx_data_i),
    .rx_last_i    (rx_last_i),
    .rx_err_i     (rx_err_i),
    .stop_req_i   (stop_req_i),
    .clr_halt_i   (clr_halt_i),
    .desc_empty_i (d_empty),
    .desc_wrap_i  (d_wrap),
    .desc_ptr_i   (d_ptr),
    .idx_o        (idx),
    .len_we_o     (len_we),
    .len_o        (len_wb),
    .stat_we_o    (stat_we),
    .stat_o       (stat_wb),
    .bwe_o        (buf_we_o),
    .baddr_o      (buf_addr_o),
    .bdata_o      (buf_data_o),
    .halted_o     (halted_o),
    .stopped_o    (stopped_o),
    .busy_set_o   (busy_set),
    .stop_done_o  (stop_done)
  );

  rxr_evt #(.N(2)) evt_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .init_i (init_i),
    .set_i  ({stop_done, busy_set}),
    .clr_i  (evt_clr_i),
    .evt_o  (evts)
  );

  assign cur_idx_o  = idx;
  assign busy_evt_o = evts[0];
  assign stop_evt_o = evts[1];

endmodule

// File: tb/rxr_ring_engine_tb_top.sv
module rxr_ring_engine_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int NDESC      = 8;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        init;
  logic [15:0] max_len;
  logic        rx_valid, rx_last, rx_err;
  logic [7:0]  rx_data;
  logic        stop_req, clr_halt;
  logic [1:0]  evt_clr;
  logic        sw_we;
  logic [2:0]  sw_idx;
  logic [1:0]  sw_sel;
  logic [31:0] sw_wdata, sw_rdata;
  logic        buf_we;
  logic [31:0] buf_addr;
  logic [7:0]  buf_data;
  logic [2:0]  cur_idx;
  logic        halted, stopped, busy_evt, stop_evt;

  int tests = 0;
  int fails = 0;
  int nw = 0;
  logic [31:0] wa [64];
  logic [7:0]  wd [64];

  always #(CLK_PERIOD / 2) clk = ~clk;

  rxr_ring_engine #(.NDESC(NDESC)) dut_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .init_i     (init),
    .max_len_i  (max_len),
    .rx_valid_i (rx_valid),
    .rx_data_i  (rx_data),
    .rx_last_i  (rx_last),
    .rx_err_i   (rx_err),
    .stop_req_i (stop_req),
    .clr_halt_i (clr_halt),
    .evt_clr_i  (evt_clr),
    .sw_we_i    (sw_we),
    .sw_idx_i   (sw_idx),
    .sw_sel_i   (sw_sel),
    .sw_wdata_i (sw_wdata),
    .sw_rdata_o (sw_rdata),
    .buf_we_o   (buf_we),
    .buf_addr_o (buf_addr),
    .buf_data_o (buf_data),
    .cur_idx_o  (cur_idx),
    .halted_o   (halted),
    .stopped_o  (stopped),
    .busy_evt_o (busy_evt),
    .stop_evt_o (stop_evt)
  );

  // Passive record of buffer writes
  always @(negedge clk) begin
    if (rst_n && buf_we) begin
      if (nw < 64) begin
        wa[nw] = buf_addr;
        wd[nw] = buf_data;
      end
      nw = nw + 1;
    end
  end

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  task automatic rd(input int idx, input logic [1:0] sel, output logic [31:0] v);
    sw_idx = idx[2:0];
    sw_sel = sel;
    #1;
    v = sw_rdata;
  endtask

  task automatic wr(input int idx, input logic [1:0] sel, input logic [31:0] d);
    sw_idx   = idx[2:0];
    sw_sel   = sel;
    sw_wdata = d;
    sw_we    = 1'b1;
    @(posedge clk); #1;
    sw_we    = 1'b0;
  endtask

  task automatic send(input int n, input int err_at, input logic [7:0] seed, input int stop_at);
    for (int i = 0; i < n; i++) begin
      rx_valid = 1'b1;
      rx_data  = seed + 8'(i);
      rx_last  = (i == n - 1);
      rx_err   = (i == err_at);
      if (i == stop_at) stop_req = 1'b1;
      @(posedge clk); #1;
    end
    rx_valid = 1'b0;
    rx_last  = 1'b0;
    rx_err   = 1'b0;
    repeat (5) @(posedge clk);
    #1;
  endtask

  task automatic chk_writes(input string req, input logic [31:0] base,
                            input int n, input logic [7:0] seed);
    int bad;
    bad = 0;
    chk(req, "buffer write count", nw, n);
    for (int i = 0; i < n && i < 64; i++)
      if (wa[i] !== base + 32'(i) || wd[i] !== seed + 8'(i)) bad++;
    chk(req, "buffer write mismatches", bad, 0);
  endtask

  task automatic t_reset_state();
    logic [31:0] v;
    rd(0, 2'd0, v); chk("R1", "desc0 status", v, 32'h8000);
    rd(7, 2'd0, v); chk("R1", "desc7 status", v, 32'hA000);
    rd(3, 2'd1, v); chk("R1", "desc3 length", v, 0);
    chk("R1", "index", cur_idx, 0);
    chk("R1", "halted/busy", {halted, busy_evt}, 0);
  endtask

  task automatic t_sw_port();
    logic [31:0] v;
    for (int i = 0; i < NDESC; i++) wr(i, 2'd2, 32'h1000 + 32'(i) * 32'h100);
    rd(3, 2'd2, v); chk("R12", "desc3 address", v, 32'h1300);
    wr(5, 2'd1, 32'h0055);
    rd(5, 2'd1, v); chk("R12", "desc5 length", v, 32'h55);
  endtask

  task automatic t_good_frame();
    logic [31:0] v;
    nw = 0;
    send(10, -1, 8'h10, -1);
    chk_writes("R2", 32'h1000, 10, 8'h10);
    rd(0, 2'd1, v); chk("R3", "length with FCS", v, 10);
    rd(0, 2'd0, v); chk("R3", "status after store", v, 32'h0000);
    chk("R3", "index advance", cur_idx, 1);
  endtask

  task automatic t_err_frame();
    logic [31:0] v;
    nw = 0;
    send(5, 2, 8'h30, -1);
    rd(1, 2'd0, v); chk("R4", "error status", v, 32'h0002);
    rd(1, 2'd1, v); chk("R4", "length", v, 5);
  endtask

  task automatic t_overrun();
    logic [31:0] v;
    max_len = 16'd6;
    nw = 0;
    send(9, -1, 8'h40, -1);
    chk_writes("R10", 32'h1200, 6, 8'h40);
    rd(2, 2'd1, v); chk("R10", "truncated length", v, 6);
    rd(2, 2'd0, v); chk("R10", "overrun status", v, 32'h0004);
    max_len = 16'd100;
  endtask

  task automatic t_one_byte();
    logic [31:0] v;
    nw = 0;
    send(1, -1, 8'h55, -1);
    chk_writes("R3", 32'h1300, 1, 8'h55);
    rd(3, 2'd1, v); chk("R3", "one-byte length", v, 1);
    chk("R3", "index after one-byte", cur_idx, 4);
  endtask

  task automatic t_wrap_end();
    logic [31:0] v;
    for (int i = 4; i < NDESC; i++) begin
      nw = 0;
      send(3, -1, 8'h60, -1);
    end
    chk_writes("R6", 32'h1700, 3, 8'h60);
    rd(7, 2'd0, v); chk("R6", "last status keeps wrap", v, 32'h2000);
    chk("R6", "index back to 0", cur_idx, 0);
  endtask

  task automatic t_busy_halt();
    logic [31:0] v;
    nw = 0;
    send(4, -1, 8'h80, -1);
    chk("R7", "writes on busy", nw, 0);
    chk("R7", "busy/halted", {busy_evt, halted}, 2'b11);
    rd(0, 2'd0, v); chk("R7", "desc0 status untouched", v, 32'h0000);
    rd(0, 2'd1, v); chk("R7", "desc0 length untouched", v, 10);
    wr(0, 2'd0, 32'h8000);
    nw = 0;
    send(3, -1, 8'h90, -1);
    chk("R8", "writes while halted", nw, 0);
    chk("R8", "index while halted", cur_idx, 0);
    clr_halt = 1'b1; @(posedge clk); #1; clr_halt = 1'b0;
    chk("R8", "halt released", halted, 0);
    nw = 0;
    send(3, -1, 8'hA0, -1);
    chk_writes("R8", 32'h1000, 3, 8'hA0);
    chk("R9", "busy sticky", busy_evt, 1);
    evt_clr = 2'b01; @(posedge clk); #1; evt_clr = 2'b00;
    chk("R9", "busy cleared", busy_evt, 0);
  endtask

  task automatic t_set_wins();
    rx_valid = 1'b1; rx_last = 1'b1; rx_data = 8'hEE;
    evt_clr  = 2'b01;
    @(posedge clk); #1;
    rx_valid = 1'b0; rx_last = 1'b0; evt_clr = 2'b00;
    repeat (2) @(posedge clk); #1;
    chk("R9", "busy set beats clear", busy_evt, 1);
    evt_clr = 2'b01; clr_halt = 1'b1;
    @(posedge clk); #1;
    evt_clr = 2'b00; clr_halt = 1'b0;
    chk("R9", "busy cleared after", {busy_evt, halted}, 0);
  endtask

  task automatic t_stop();
    logic [31:0] v;
    wr(1, 2'd0, 32'h8000);
    nw = 0;
    send(8, -1, 8'h70, 3);
    chk_writes("R11", 32'h1100, 8, 8'h70);
    rd(1, 2'd1, v); chk("R11", "frame finished length", v, 8);
    rd(1, 2'd0, v); chk("R11", "frame finished status", v, 32'h0000);
    chk("R11", "stopped/stop event", {stopped, stop_evt}, 2'b11);
    nw = 0;
    send(4, -1, 8'hB0, -1);
    chk("R11", "writes while stopped", nw, 0);
    chk("R11", "no busy while stopped", busy_evt, 0);
    stop_req = 1'b0;
    repeat (2) @(posedge clk); #1;
    chk("R11", "resumed", stopped, 0);
    chk("R9", "stop event sticky", stop_evt, 1);
    evt_clr = 2'b10; @(posedge clk); #1; evt_clr = 2'b00;
    chk("R9", "stop event cleared", stop_evt, 0);
  endtask

  task automatic t_init();
    logic [31:0] v;
    init = 1'b1; @(posedge clk); #1; init = 1'b0;
    chk("R1", "index after init", cur_idx, 0);
    rd(0, 2'd0, v); chk("R1", "desc0 rearmed", v, 32'h8000);
    rd(0, 2'd1, v); chk("R1", "desc0 length cleared", v, 0);
    rd(7, 2'd0, v); chk("R1", "desc7 wrap", v, 32'hA000);
    rd(3, 2'd2, v); chk("R1", "address kept", v, 32'h1300);
  endtask

  task automatic t_early_wrap();
    logic [31:0] v;
    wr(1, 2'd0, 32'hA000);
    nw = 0;
    send(2, -1, 8'hC0, -1);
    send(2, -1, 8'hD0, -1);
    chk("R6", "index back after wrap bit", cur_idx, 0);
    rd(1, 2'd0, v); chk("R6", "desc1 status", v, 32'h2000);
    chk("R6", "write count", nw, 4);
  endtask

  initial begin
    rst_n = 1'b0; init = 1'b0; max_len = 16'd100;
    rx_valid = 1'b0; rx_last = 1'b0; rx_err = 1'b0; rx_data = 8'h00;
    stop_req = 1'b0; clr_halt = 1'b0; evt_clr = 2'b00;
    sw_we = 1'b0; sw_idx = 3'd0; sw_sel = 2'd0; sw_wdata = 32'h0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(posedge clk); #1;
    t_reset_state();
    t_sw_port();
    t_good_frame();
    t_err_frame();
    t_overrun();
    t_one_byte();
    t_wrap_end();
    t_busy_halt();
    t_set_wins();
    t_stop();
    t_init();
    t_early_wrap();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    tests++;
    fails++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule